// File: doc/BRIEF.md
# Machine Mode Control Register

This block is one 8-bit control register in a retro home-computer core. It holds which machine personality the core emulates and which display-timing personality it runs. Software writes it through a simple register-bus port: one data byte with a write strobe. Each field has its own write rule. The machine type can be chosen only while the core is still in its start-up configuration state. The display timing can be retuned at any time when the write says so. A user lock can freeze that retuning outside configuration.

Every write made while in configuration also turns off the boot ROM, and that enable stays off until a hard reset. Reads return the live fields, the lock and one status bit that mirrors an external palette phase flag. The port-decode personality that the rest of the core uses comes from the display timing, not from the machine type.

The register has two resets. A hard reset restores the power-on state. A soft reset keeps every field and flag.

Top module: `mode_ctrl_reg`

## Requirements
- R1: The read byte is {pal_phase_i, timing, lock, machine}: bit 7 is the palette phase flag (0 = next palette write hits the RGB byte, 1 = it hits the priority/extra-blue byte), bits 6:4 are the display timing, bit 3 is the user lock and bits 2:0 are the machine type.
- R2: Both 3-bit fields use 000 as the special code (configuration for the machine type, internal use for the timing) and 001 to 100 as the four personalities. A write carrying 101, 110 or 111 for a field leaves that field unchanged, while the other parts of the same write still apply.
- R3: Data bits 2:0 load the machine type only when the machine type held before the write is 000. In any other mode the machine type cannot change.
- R4: A write with data bit 7 set loads data bits 6:4 into the display timing, in any mode.
- R5: A write with data bit 7 clear never changes the display timing.
- R6: Any write made while the machine type is 000 clears boot_rom_en_o on the next clock edge. Once cleared, it stays 0 until a hard reset.
- R7: A write with data bit 3 set inverts the user lock. A write with bit 3 clear keeps the lock as it is.
- R8: While the user lock is 1 and the machine type is not 000, writes with bit 7 set leave the display timing unchanged.
- R9: port_pers_o always equals the display-timing field, whatever the machine type is.
- R10: A hard reset (synchronous, active low) sets the machine type to 000, the timing to 000, boot_rom_en_o to 1 and the lock to 0.
- R11: A soft reset (synchronous, active low) keeps the machine type, the timing, the boot-ROM enable and the lock. A write presented in the same cycle is ignored.
- R12: cfg_mode_o is 1 exactly when the machine type is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous active-low power-on reset |
| soft_rst_n | input | 1 | Synchronous active-low soft reset; blocks writes, keeps state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| pal_phase_i | input | 1 | External palette byte-phase flag, mirrored on read bit 7 |
| rd_data | output | 8 | Current register read value |
| machine_o | output | 3 | Machine type field |
| timing_o | output | 3 | Display timing field |
| cfg_mode_o | output | 1 | High while the machine type is configuration (000) |
| boot_rom_en_o | output | 1 | Boot ROM enable |
| user_lock_o | output | 1 | User lock on display timing |
| port_pers_o | output | 3 | Port-decode personality select, taken from the display timing |

## Verification
Every stored result is a single register stage. The fields, flags, cfg_mode_o and port_pers_o are due one clock edge after the write strobe. rd_data also follows pal_phase_i within the same cycle, with no register on that path. The bench drives each write on a falling edge and samples on the next falling edge, which is half a period after the one edge that matters. It sweeps all 256 write bytes from every starting machine type, with and without the lock, and compares each result against a next-state model computed from the rules above.

// File: rtl/mmcr_pkg.sv
// Package: shared encodings and helpers for the machine mode control register.
// Assumes both mode fields share one 3-bit code space with codes 0..4 legal.
package mmcr_pkg;

    localparam int unsigned FIELD_W  = 3;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned MAX_CODE = 4;

    // Field positions inside the register byte (software relies on these)
    localparam int unsigned MACH_LSB = 0;
    localparam int unsigned LOCK_BIT = 3;
    localparam int unsigned TIM_LSB  = 4;
    localparam int unsigned GATE_BIT = 7;

    typedef enum logic [FIELD_W-1:0] {
        PERS_SPECIAL = 3'd0,  // config (machine) or internal use (timing)
        PERS_BASE48  = 3'd1,
        PERS_BANK128 = 3'd2,
        PERS_PLUS    = 3'd3,
        PERS_ALT     = 3'd4
    } pers_e;

    // True when a field code is one of the defined encodings
    function automatic logic code_legal(input logic [FIELD_W-1:0] c);
        return c <= FIELD_W'(MAX_CODE);
    endfunction

endpackage

// File: rtl/mmcr_wr_gate.sv
// Module: write-permission gate. It turns a raw bus write into per-field
// load, clear and toggle strobes, based on the current mode and lock.
// Assumes: cfg_i and lock_i are the registered values before this write.
module mmcr_wr_gate
    import mmcr_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          wr_en,
    input  logic          soft_rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          cfg_i,
    input  logic          lock_i,
    output logic          mach_ld_o,
    output logic          tim_ld_o,
    output logic          boot_clr_o,
    output logic          lock_tgl_o
);

    logic wr_live;

    // Purpose: a soft reset cycle swallows any write
    always_comb wr_live = wr_en & soft_rst_n;

    // Purpose: derive each field's write permission from mode, gate bit and lock
    always_comb begin
        mach_ld_o  = wr_live & cfg_i;
        tim_ld_o   = wr_live & wr_data[GATE_BIT] & (cfg_i | ~lock_i);
        boot_clr_o = wr_live & cfg_i;
        lock_tgl_o = wr_live & wr_data[LOCK_BIT];
    end

endmodule

// File: rtl/mmcr_field_reg.sv
// Module: one 3-bit mode field with a hard-reset value. A load carrying an
// undefined code is discarded, so the field only ever holds legal codes.
// Assumes: hard reset is synchronous and active low; no soft reset here
// because the soft reset preserves the field (writes are gated upstream).
module mmcr_field_reg
    import mmcr_pkg::*;
#(
    parameter int unsigned         W       = FIELD_W,
    parameter logic [FIELD_W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         hard_rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q;

    // Purpose: hold the field; take a load only when the code is defined
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            q <= W'(RST_VAL);
        else if (ld_i && code_legal(FIELD_W'(d_i)))
            q <= d_i;
    end

    assign q_o = q;

    // R2: field never holds an undefined encoding
    a_r2_field_legal: assert property (@(posedge clk) disable iff (!hard_rst_n)
        q <= W'(MAX_CODE));

    // R2: a load with an undefined code leaves the field as it was
    a_r2_illegal_kept: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (ld_i && d_i > W'(MAX_CODE)) |=> $stable(q));

endmodule

// File: rtl/mmcr_flags.sv
// Module: boot-ROM enable and user-lock flags.
// Boot enable only falls (restored by hard reset); lock toggles on request.
// Assumes: strobes are already gated by mode and soft reset.
module mmcr_flags (
    input  logic clk,
    input  logic hard_rst_n,
    input  logic boot_clr_i,
    input  logic lock_tgl_i,
    output logic boot_en_o,
    output logic lock_o
);

    logic boot_q;
    logic lock_q;

    // Purpose: boot ROM enable, set by hard reset, cleared by a config write
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            boot_q <= 1'b1;
        else if (boot_clr_i)
            boot_q <= 1'b0;
    end

    // Purpose: user lock, cleared by hard reset, inverted by each toggle
    always_ff @(posedge clk) begin
        if (!hard_rst_n)
            lock_q <= 1'b0;
        else if (lock_tgl_i)
            lock_q <= ~lock_q;
    end

    assign boot_en_o = boot_q;
    assign lock_o    = lock_q;

    // R6: once off, boot enable stays off until hard reset
    a_r6_boot_sticky: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !boot_q |=> !boot_q);

    // R7: a toggle request inverts the lock
    a_r7_lock_flip: assert property (@(posedge clk) disable iff (!hard_rst_n)
        lock_tgl_i |=> (lock_q != $past(lock_q)));

    // R7: without a toggle the lock holds
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !lock_tgl_i |=> $stable(lock_q));

endmodule

// File: rtl/mode_ctrl_reg.sv
// Module: machine mode control register (top).
// Holds machine type and display timing with mode-dependent write rules,
// drives boot-ROM enable, user lock, and the port-decode personality that
// follows the display timing. Read data is combinational from the state.
// Assumes: single-cycle write strobe, both resets synchronous active low.
module mode_ctrl_reg
    import mmcr_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned FW = FIELD_W
) (
    input  logic          clk,
    input  logic          hard_rst_n,
    input  logic          soft_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pal_phase_i,
    output logic [DW-1:0] rd_data,
    output logic [FW-1:0] machine_o,
    output logic [FW-1:0] timing_o,
    output logic          cfg_mode_o,
    output logic          boot_rom_en_o,
    output logic          user_lock_o,
    output logic [FW-1:0] port_pers_o
);

    localparam int unsigned NFIELD = 2;
    localparam int unsigned F_MACH = 0;
    localparam int unsigned F_TIM  = 1;
    localparam int unsigned LSB_OF [NFIELD] = '{MACH_LSB, TIM_LSB};

    logic [FW-1:0] fld_q  [NFIELD];
    logic          fld_ld [NFIELD];
    logic          cfg;
    logic          lock;
    logic          boot_clr;
    logic          lock_tgl;

    // Purpose: configuration state is machine code 000
    always_comb cfg = (fld_q[F_MACH] == FW'(PERS_SPECIAL));

    mmcr_wr_gate #(.DW(DW)) u_gate (
        .wr_en      (wr_en),
        .soft_rst_n (soft_rst_n),
        .wr_data    (wr_data),
        .cfg_i      (cfg),
        .lock_i     (lock),
        .mach_ld_o  (fld_ld[F_MACH]),
        .tim_ld_o   (fld_ld[F_TIM]),
        .boot_clr_o (boot_clr),
        .lock_tgl_o (lock_tgl)
    );

    // One register per mode field, each picking its slice of the write byte
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        mmcr_field_reg #(.W(FW), .RST_VAL(FW'(PERS_SPECIAL))) u_fld (
            .clk        (clk),
            .hard_rst_n (hard_rst_n),
            .ld_i       (fld_ld[g]),
            .d_i        (wr_data[LSB_OF[g] +: FW]),
            .q_o        (fld_q[g])
        );
    end

    mmcr_flags u_flags (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .boot_clr_i (boot_clr),
        .lock_tgl_i (lock_tgl),
        .boot_en_o  (boot_rom_en_o),
        .lock_o     (lock)
    );

    // Purpose: assemble the read byte from live state and palette phase
    always_comb begin
        rd_data = '0;
        rd_data[GATE_BIT]              = pal_phase_i;
        rd_data[TIM_LSB +: FW]         = fld_q[F_TIM];
        rd_data[LOCK_BIT]              = lock;
        rd_data[MACH_LSB +: FW]        = fld_q[F_MACH];
    end

    assign machine_o   = fld_q[F_MACH];
    assign timing_o    = fld_q[F_TIM];
    assign cfg_mode_o  = cfg;
    assign user_lock_o = lock;
    assign port_pers_o = fld_q[F_TIM];

    // R3: outside config the machine type cannot change
    a_r3_mach_frozen: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !cfg_mode_o |=> $stable(machine_o));

    // R5: gate bit clear leaves timing alone
    a_r5_tim_needs_gate: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (wr_en && !wr_data[GATE_BIT]) |=> $stable(timing_o));

    // R8: lock freezes timing outside config
    a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (user_lock_o && !cfg_mode_o) |=> $stable(timing_o));

    // R6: a write in config turns off boot ROM
    a_r6_cfg_write_clears: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (wr_en && soft_rst_n && cfg_mode_o) |=> !boot_rom_en_o);

    // R11: soft reset cycle leaves all state unchanged
    a_r11_soft_keeps: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !soft_rst_n |=> ($stable(machine_o) && $stable(timing_o)
                         && $stable(boot_rom_en_o) && $stable(user_lock_o)));

endmodule

// File: tb/sim_mode_ctrl_reg.sv
// Bench: sweeps all 256 write bytes from each start state, lock on and off,
// against a next-state model computed from the requirements.
module sim_mode_ctrl_reg;

    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       soft_rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pal_phase_i = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] machine_o, timing_o, port_pers_o;
    logic       cfg_mode_o, boot_rom_en_o, user_lock_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state
    logic [2:0] m_mach, m_tim;
    logic       m_boot, m_lock;

    always #10 clk = ~clk;  // 50 MHz

    mode_ctrl_reg u0 (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .pal_phase_i(pal_phase_i),
        .rd_data(rd_data), .machine_o(machine_o), .timing_o(timing_o),
        .cfg_mode_o(cfg_mode_o), .boot_rom_en_o(boot_rom_en_o),
        .user_lock_o(user_lock_o), .port_pers_o(port_pers_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every output with the model
    task automatic chk_all(input string mt, input string tt);
        chk(mt, machine_o, m_mach);
        chk(tt, timing_o, m_tim);
        chk("R6 boot", boot_rom_en_o, m_boot);
        chk("R7 lock", user_lock_o, m_lock);
        chk("R9 pers", port_pers_o, m_tim);
        chk("R12 cfg", cfg_mode_o, (m_mach == 3'd0));
        chk("R1 read", rd_data, {pal_phase_i, m_tim, m_lock, m_mach});
    endtask

    task automatic hard_reset();
        @(negedge clk);
        hard_rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        hard_rst_n = 1'b1;
        m_mach = 3'd0; m_tim = 3'd0; m_boot = 1'b1; m_lock = 1'b0;
    endtask

    // one write, model updated from the rules; returns check tags
    task automatic do_write(input logic [7:0] d, output string mt, output string tt);
        logic cfg;
        cfg = (m_mach == 3'd0);
        mt = (d[2:0] > 3'd4 && cfg) ? "R2 mach" : "R3 mach";
        if (!d[7])                    tt = "R5 tim";
        else if (!cfg && m_lock)      tt = "R8 tim";
        else if (d[6:4] > 3'd4)       tt = "R2 tim";
        else                          tt = "R4 tim";
        wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (cfg && d[2:0] <= 3'd4) m_mach = d[2:0];
        if (d[7] && d[6:4] <= 3'd4 && (cfg || !m_lock)) m_tim = d[6:4];
        if (cfg) m_boot = 1'b0;
        if (d[3]) m_lock = ~m_lock;
    endtask

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        string mt, tt;
        hard_reset();
        @(negedge clk);
        // R10: hard reset state
        chk("R10 mach", machine_o, 0);
        chk("R10 tim", timing_o, 0);
        chk("R10 boot", boot_rom_en_o, 1);
        chk("R10 lock", user_lock_o, 0);

        for (int sc = 0; sc < 6; sc++) begin
            for (int lk = 0; lk < 2; lk++) begin
                for (int d = 0; d < 256; d++) begin
                    hard_reset();
                    if (lk == 1) do_write(8'h08, mt, tt);
                    if (sc < 5) do_write(8'h80 | 8'h20 | 8'(sc), mt, tt);
                    pal_phase_i = d[0] ^ d[5];
                    do_write(8'(d), mt, tt);
                    chk_all(mt, tt);
                end
            end
        end

        // R11: soft reset keeps state and drops a concurrent write
        hard_reset();
        do_write(8'hBB, mt, tt);   // mach 3, timing 3, lock on, boot off
        chk_all(mt, tt);
        @(negedge clk);
        soft_rst_n = 1'b0; wr_en = 1'b1; wr_data = 8'hC8;
        @(negedge clk);
        soft_rst_n = 1'b1; wr_en = 1'b0;
        chk_all("R11 mach", "R11 tim");
        chk("R11 lock", user_lock_o, 1);

        // R6: boot stays off after leaving config and further writes
        do_write(8'h08, mt, tt);
        chk("R6 sticky", boot_rom_en_o, 0);
        // R8: unlocked now, timing can move outside config
        do_write(8'h91, mt, tt);
        chk("R4 unlocked", timing_o, 1);
        chk("R3 frozen", machine_o, 3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule